// File: doc/BRIEF.md
# Serial Shifter with Carry, Sticky and Overflow Flags

This block shifts a byte, word or 32-bit operand by a count from 0 to 31. It moves the operand one bit position per clock cycle. Three kinds of shift are offered: toward the most significant bit, a zero-filling shift toward the least significant bit, and a sign-replicating shift toward the least significant bit. While the operand moves, the block keeps a carry flag, a sticky flag, an overflow flag and a negative flag. It also reports whether the final value is zero. A later stage can use the carry and sticky pair to decide rounding after a right shift.

A caller presents the operand, count, width and kind together with a one-cycle `start` pulse while `busy` is low. The block samples those inputs on that edge and raises `busy`. It then spends one cycle per bit position and pulses `done` for one cycle. The result and flags hold their values from the `done` cycle until the next accepted `start`. The interface is a plain start/done handshake, and the caller must not assume any queue: a start while `busy` is high is dropped, not deferred.

Top module: `shf_sticky_top`

## Requirements
- R1: With `kind`=2'b00 (left), the result is the operand at the selected width shifted toward the MSB by `count`, with zeros entering at bit 0. Bits that move past the width MSB are lost. Width encoding: `width_sel` 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 or 2'b11 = 32 bits. Operand bits above the width are ignored and result bits above it read 0.
- R2: With `kind`=2'b01 (logical right), the result is the operand shifted toward bit 0 by `count`, with zeros entering at the width MSB.
- R3: With `kind`=2'b10 or 2'b11 (arithmetic right), the value at the width MSB is copied into the vacated MSB at every step.
- R4: `flag_c` is the last bit shifted out of the operand. It is 0 when `count` is 0.
- R5: `flag_st` is 1 exactly when a 1 was in the carry position and a later step shifted it out of the carry position. In other words, at least one bit shifted out before the final one was 1. It is cleared at start and is 0 for a count of 0.
- R6: On a left shift, `flag_v` is 1 if the width MSB changed value at any step, even when it later changed back. On both right shifts `flag_v` is 0.
- R7: `flag_n` equals the width MSB of the result, including when `count` is 0.
- R8: `flag_z` is 1 exactly when the result at the selected width is all zeros.
- R9: If `start` is sampled on edge E while `busy` is low, `done` is high for exactly one cycle after edge E+count+1. `busy` is high from edge E until that same edge. Out of reset `busy` and `done` are 0.
- R10: A `start` sampled while `busy` is high is ignored. It changes neither the operation in progress, its timing nor its result, and it produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a shift; sampled only while `busy` is low |
| operand | input | 32 | Value to shift; only the low bits of the selected width are used |
| count | input | 5 | Number of bit positions, 0 to 31 |
| width_sel | input | 2 | 00 byte, 01 word, 10/11 32-bit |
| kind | input | 2 | 00 left, 01 logical right, 10/11 arithmetic right |
| busy | output | 1 | A shift is in progress |
| done | output | 1 | One-cycle pulse: result and flags are final |
| result | output | 32 | Shifted value, zero above the selected width |
| flag_c | output | 1 | Last bit shifted out |
| flag_st | output | 1 | A 1 passed through carry and was shifted out |
| flag_v | output | 1 | MSB changed at some step of a left shift |
| flag_n | output | 1 | MSB of the result at the selected width |
| flag_z | output | 1 | Result at the selected width is zero |

## Verification
Directed operands cover three flag behaviours:
- Shift-out pairs such as 0x03 versus 0x02 by two separate a sticky flag from a carry-only flag.
- A byte left shift of 0x40 changes the MSB once, while 0xC0 shifted by two holds the MSB steady and then drops it, which separates "changed at any step" from "differs at the end".
- Negative word operands under the two right shifts separate sign fill from zero fill.

Seeded random operands, counts, widths and kinds, with garbage above the selected width, separate correct masking and count-0 handling from width or off-by-one faults. Latency is measured on every run, and a start injected mid-shift shows whether an in-flight operation can be disturbed.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    K_LEFT = 2'b00,
    K_LSR  = 2'b01,
    K_ASR  = 2'b10,
    K_ASR2 = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    W_BYTE  = 2'b00,
    W_WORD  = 2'b01,
    W_LONG  = 2'b10,
    W_LONG2 = 2'b11
  } width_e;

  typedef struct packed {
    logic c;
    logic st;
    logic v;
  } sflags_t;

  // Index of the width lane: 0 byte, 1 word, 2 long.
  function automatic logic [1:0] lane_of(width_e w);
    case (w)
      W_BYTE:  return 2'd0;
      W_WORD:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             load,
  output logic             step,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] rem_q;

  assign load = start && !busy;
  assign step = busy && (rem_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          rem_q <= count;
        end
      end else if (rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a shift with steps left keeps running regardless of start
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem_q != '0) |=> busy);

  // R9: remaining count only moves down while running
  p_rem_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (rem_q == $past(rem_q) - 1'b1));

endmodule

// File: rtl/shf_step.sv
module shf_step
  import shf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_i,
  input  width_e            wsel_i,
  input  kind_e             kind_i,
  input  sflags_t           fl_i,
  output logic [DATA_W-1:0] op_o,
  output sflags_t           fl_o
);

  localparam int LANES = 3;

  logic [DATA_W-1:0] cand [LANES];
  logic [LANES-1:0]  outb;
  logic [LANES-1:0]  chg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = DATA_W >> (LANES - 1 - g);
    logic [LW-1:0] seg;
    logic [LW-1:0] res;
    assign seg = op_i[LW-1:0];

    always_comb begin
      res    = seg;
      outb[g] = 1'b0;
      chg[g]  = 1'b0;
      case (kind_i)
        K_LEFT: begin
          res     = {seg[LW-2:0], 1'b0};
          outb[g] = seg[LW-1];
          chg[g]  = seg[LW-1] ^ seg[LW-2];
        end
        K_LSR: begin
          res     = {1'b0, seg[LW-1:1]};
          outb[g] = seg[0];
        end
        default: begin
          res     = {seg[LW-1], seg[LW-1:1]};
          outb[g] = seg[0];
        end
      endcase
    end

    always_comb begin
      cand[g]        = '0;
      cand[g][LW-1:0] = res;
    end
  end

  logic [1:0] ln;
  assign ln = lane_of(wsel_i);

  always_comb begin
    op_o  = cand[ln];
    fl_o.c  = outb[ln];
    fl_o.st = fl_i.st | fl_i.c;
    fl_o.v  = fl_i.v | chg[ln];
  end

endmodule

// File: rtl/shf_flags.sv
module shf_flags
  import shf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  width_e            wsel_i,
  output logic              n_o,
  output logic              z_o
);

  localparam int LANES = 3;

  logic [LANES-1:0] n_l;
  logic [LANES-1:0] z_l;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = DATA_W >> (LANES - 1 - g);
    assign n_l[g] = res_i[LW-1];
    assign z_l[g] = (res_i[LW-1:0] == '0);
  end

  logic [1:0] ln;
  assign ln = lane_of(wsel_i);
  assign n_o = n_l[ln];
  assign z_o = z_l[ln];

endmodule

// File: rtl/shf_sticky_top.sv
module shf_sticky_top
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        width_sel,
  input  logic [1:0]        kind,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              flag_c,
  output logic              flag_st,
  output logic              flag_v,
  output logic              flag_n,
  output logic              flag_z
);

  localparam int BYTE_W = DATA_W / 4;
  localparam int WORD_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic load, step;

  shf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .count (count),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  logic [DATA_W-1:0] op_q, op_nxt, in_mask;
  width_e            wsel_q;
  kind_e             kind_q;
  sflags_t           fl_q, fl_nxt;

  always_comb begin
    case (width_e'(width_sel))
      W_BYTE:  in_mask = ONES >> (DATA_W - BYTE_W);
      W_WORD:  in_mask = ONES >> (DATA_W - WORD_W);
      default: in_mask = ONES;
    endcase
  end

  shf_step #(.DATA_W(DATA_W)) u_step (
    .op_i   (op_q),
    .wsel_i (wsel_q),
    .kind_i (kind_q),
    .fl_i   (fl_q),
    .op_o   (op_nxt),
    .fl_o   (fl_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      wsel_q <= W_BYTE;
      kind_q <= K_LEFT;
      fl_q   <= '0;
    end else if (load) begin
      op_q   <= operand & in_mask;
      wsel_q <= width_e'(width_sel);
      kind_q <= kind_e'(kind);
      fl_q   <= '0;
    end else if (step) begin
      op_q <= op_nxt;
      fl_q <= fl_nxt;
    end
  end

  shf_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i  (op_q),
    .wsel_i (wsel_q),
    .n_o    (flag_n),
    .z_o    (flag_z)
  );

  assign result  = op_q;
  assign flag_c  = fl_q.c;
  assign flag_st = fl_q.st;
  assign flag_v  = fl_q.v;

  // R5: sticky can only rise after carry held a 1
  p_st_from_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_q.st) |-> $past(fl_q.c));

  // R6: right shifts finish with overflow clear
  p_right_no_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind_q != K_LEFT) |-> !flag_v);

  // R6: once overflow is seen during a shift it stays
  p_v_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fl_q.v) |=> fl_q.v);

  // R4: a zero count finishes next cycle with C, ST, V clear
  p_zero_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && count == '0) |=> ##1 (done && !flag_c && !flag_st && !flag_v));

  // R1: nothing above the selected width survives in a byte shift
  p_byte_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wsel_q == W_BYTE) |-> (result[DATA_W-1:BYTE_W] == '0));

endmodule

// File: tb/shf_sticky_top_tb_top.sv
`timescale 1ns/1ps
module shf_sticky_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  count = '0;
  logic [1:0]  width_sel = '0;
  logic [1:0]  kind = '0;
  logic        busy, done, flag_c, flag_st, flag_v, flag_n, flag_z;
  logic [31:0] result;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shf_sticky_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .count(count), .width_sel(width_sel), .kind(kind),
    .busy(busy), .done(done), .result(result),
    .flag_c(flag_c), .flag_st(flag_st), .flag_v(flag_v),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Expected values from the requirements
  task automatic model(input logic [31:0] op, input int cnt, input logic [1:0] ws,
                       input logic [1:0] kd, output logic [31:0] r,
                       output logic c, output logic st, output logic v,
                       output logic n, output logic z);
    int lw;
    logic [31:0] m, x, nx;
    logic o;
    lw = (ws == 2'b00) ? 8 : (ws == 2'b01) ? 16 : 32;
    m = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 1);
    x = op & m;
    c = 0; st = 0; v = 0;
    for (int i = 0; i < cnt; i++) begin
      if (kd == 2'b00) begin
        o  = x[lw-1];
        nx = (x << 1) & m;
        if (nx[lw-1] != x[lw-1]) v = 1;
      end else if (kd == 2'b01) begin
        o  = x[0];
        nx = x >> 1;
      end else begin
        o  = x[0];
        nx = (x >> 1) | ({31'd0, x[lw-1]} << (lw - 1));
      end
      st = st | c;
      c  = o;
      x  = nx;
    end
    r = x;
    n = x[lw-1];
    z = (x == 0);
  endtask

  task automatic run_one(input logic [31:0] op, input int cnt, input logic [1:0] ws,
                         input logic [1:0] kd, input bit intrude);
    logic [31:0] er;
    logic ec, est, ev, en, ez;
    int lat;
    string rq;
    model(op, cnt, ws, kd, er, ec, est, ev, en, ez);
    rq = (kd == 2'b00) ? "R1" : (kd == 2'b01) ? "R2" : "R3";
    @(negedge clk);
    operand = op; count = cnt[4:0]; width_sel = ws; kind = kd; start = 1;
    @(negedge clk);
    start = 0;
    lat = 0;
    while (!done && lat < 100) begin
      if (intrude && lat == 3) begin
        operand = ~op; count = 5'd1; kind = ~kd; start = 1;
      end
      @(negedge clk);
      start = 0;
      lat++;
    end
    chk(lat == cnt + 1, "R9 latency", lat, cnt + 1);
    chk(result == er, rq, result, er);
    chk(flag_c == ec, "R4 carry", flag_c, ec);
    chk(flag_st == est, "R5 sticky", flag_st, est);
    chk(flag_v == ev, "R6 overflow", flag_v, ev);
    chk(flag_n == en, "R7 negative", flag_n, en);
    chk(flag_z == ez, "R8 zero", flag_z, ez);
    @(negedge clk);
    chk(!done && !busy, "R9 single done", {30'd0, busy, done}, 0);
    if (intrude) begin
      repeat (3) begin
        @(negedge clk);
        chk(!done, "R10 no extra done", done, 0);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R9 reset", {30'd0, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R9 idle after reset", {30'd0, busy, done}, 0);

    run_one(32'h0000_0040, 1, 2'b00, 2'b00, 0);  // R6 MSB change
    run_one(32'h0000_00C0, 2, 2'b00, 2'b00, 0);  // R6 steady then change
    run_one(32'h0000_0003, 2, 2'b00, 2'b01, 0);  // R5 sticky set
    run_one(32'h0000_0002, 2, 2'b00, 2'b01, 0);  // R5 carry only
    run_one(32'h0000_8001, 1, 2'b01, 2'b10, 0);  // R3 sign fill
    run_one(32'h0000_8001, 3, 2'b01, 2'b01, 0);  // R2 zero fill
    run_one(32'h8000_0000, 0, 2'b10, 2'b00, 0);  // R7 count zero
    run_one(32'hFFFF_FF00, 1, 2'b00, 2'b00, 0);  // R1 upper bits ignored, R8
    run_one(32'hDEAD_BEEF, 31, 2'b11, 2'b11, 0); // R3 full count
    run_one(32'h1234_5678, 10, 2'b10, 2'b00, 1); // R10 intrusion

    for (int i = 0; i < 300; i++) begin
      run_one($urandom(), int'($urandom_range(0, 31)), 2'($urandom_range(0, 3)),
              2'($urandom_range(0, 3)), (i % 25) == 0);
    end
    report();
  end

endmodule